// File: doc/BRIEF.md
# Self-Reloading Four-Bit Counter with Serial Select Output

This block is a four-bit synchronous up-counter whose synchronous clear and synchronous parallel load are driven by decodes of its own state rather than by outside pins. Clear wins over load, and load wins over counting. Because of this feedback, the sixteen states split into short traps. The lower half resets to zero every few cycles. The upper half settles into a loop between 1100 and 1110.

An eight-way selector sits on the low three state bits. It picks one bit of a constant pattern and drives it out as a serial bit stream `y`. Two count enables gate the increment only. The decoded clear and load act whatever the enables are. A test preset port forces any state in one cycle, so every successor can be checked directly.

Top module: `reload_counter`

## Requirements
- R1: While `rst_n` is low the state is 0000, asynchronously.
- R2: When state bit 3 is 0 and state bit 1 is 1, the next state is 0000 at the next clock, whatever the enables are. This takes priority over R3.
- R3: When state bits 2 and 1 are both 1 and R2 does not apply, the next state is 1100 (parameter `RELOAD_VAL`), whatever the enables are.
- R4: When neither R2 nor R3 applies and `cnt_en` and `carry_en` are both 1, the state increments by one.
- R5: When neither R2 nor R3 applies and either enable is 0, the state holds.
- R6: `carry` is 1 exactly when the state is 1111 and `carry_en` is 1, combinationally.
- R7: `y` equals bit number {Q2,Q1,Q0} of parameter `SEL_PATTERN`, combinationally. The default is 8'b0011_1010, so codes 0..7 give 0,1,0,1,1,1,0,0. Starting from 0000 with both enables high, `y` repeats 0,1,0.
- R8: When `preset_en` is 1, the next state is `preset_val`, overriding R2 to R5.
- R9: With both enables high, the trajectories are 0000→0001→0010→0000, 0011→0000, 0100→0101→0110→0000, 0111→0000, 1000→1001→1010→1011→1100→1101→1110→1100, and 1111→1100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_en | input | 1 | Count enable (parallel) |
| carry_en | input | 1 | Count enable that also gates `carry` |
| preset_en | input | 1 | Test preset strobe |
| preset_val | input | 4 | Test preset state |
| q | output | 4 | Counter state Q3..Q0 |
| carry | output | 1 | Terminal-count carry |
| y | output | 1 | Selected serial bit |

## Verification
From reset, the upper loop and the states 0011, 0111 and 1111 cannot be reached, because the lower trap always falls back to zero. The bench therefore uses the preset port to place the counter in each of the sixteen states. It checks the select output there and then checks the single successor. The forced decodes are also exercised with the enables low, to show that clear and load do not depend on them.

// File: rtl/reload_counter.sv
module reload_counter #(
  parameter int          W           = 4,
  parameter logic [W-1:0] RELOAD_VAL = 4'b1100,
  parameter logic [7:0]  SEL_PATTERN = 8'b0011_1010
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         carry_en,
  input  logic         preset_en,
  input  logic [W-1:0] preset_val,
  output logic [W-1:0] q,
  output logic         carry,
  output logic         y
);
  localparam logic [W-1:0] ALL_ONES = '1;

  logic clr_n, ld_n;
  logic [W-1:0] nxt;

  assign clr_n = ~(~q[3] & q[1]);
  assign ld_n  = ~(q[2] & q[1]);

  always_comb begin
    if (preset_en)             nxt = preset_val;
    else if (!clr_n)           nxt = '0;
    else if (!ld_n)            nxt = RELOAD_VAL;
    else if (cnt_en && carry_en) nxt = q + 1'b1;
    else                       nxt = q;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) q <= '0;
    else        q <= nxt;

  assign carry = (q == ALL_ONES) & carry_en;
  assign y     = SEL_PATTERN[q[2:0]];
endmodule

module reload_counter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cnt_en,
  input logic       carry_en,
  input logic       preset_en,
  input logic [3:0] preset_val,
  input logic [3:0] q,
  input logic       carry
);
  logic dec_clr, dec_ld;
  assign dec_clr = !q[3] && q[1];
  assign dec_ld  = q[2] && q[1] && !dec_clr;

  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_clr && !preset_en) |=> (q == 4'b0000));
  p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_ld && !preset_en) |=> (q == 4'b1100));
  p_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_clr && !dec_ld && !preset_en && cnt_en && carry_en) |=> (q == $past(q) + 4'd1));
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_clr && !dec_ld && !preset_en && !(cnt_en && carry_en)) |=> $stable(q));
  p_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    carry |-> (q == 4'b1111 && carry_en));
  p_preset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    preset_en |=> (q == $past(preset_val)));
endmodule

bind reload_counter reload_counter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .carry_en(carry_en),
  .preset_en(preset_en), .preset_val(preset_val), .q(q), .carry(carry)
);

// File: tb/sim_reload_counter.sv
`timescale 1ns/1ps
module sim_reload_counter;
  logic clk = 0, rst_n = 0, cnt_en = 0, carry_en = 0, preset_en = 0;
  logic [3:0] preset_val = '0;
  logic [3:0] q;
  logic carry, y;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  reload_counter u0 (.clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .carry_en(carry_en),
    .preset_en(preset_en), .preset_val(preset_val), .q(q), .carry(carry), .y(y));

  // R9 successor table indexed by state, with the R7 select bit for that state
  localparam logic [3:0] SUCC [16] = '{4'h1,4'h2,4'h0,4'h0,4'h5,4'h6,4'h0,4'h0,
                                       4'h9,4'hA,4'hB,4'hC,4'hD,4'hE,4'hC,4'hC};
  localparam logic       YEXP [16] = '{0,1,0,1,1,1,0,0, 0,1,0,1,1,1,0,0};

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic force_state(input logic [3:0] s);
    @(negedge clk); preset_en = 1; preset_val = s;
    @(posedge clk); #1; preset_en = 0;
    chk("R8 preset", q, s);
  endtask

  task automatic step;
    @(posedge clk); #1;
  endtask

  initial begin
    #10000000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #12;
    chk("R1 reset", q, 4'h0);
    @(negedge clk); rst_n = 1; cnt_en = 1; carry_en = 1;

    for (int s = 0; s < 16; s++) begin
      force_state(4'(s));
      chk("R7 select", {3'b0, y}, {3'b0, YEXP[s]});
      chk("R6 carry", {3'b0, carry}, {3'b0, s == 15});
      step();
      chk("R9 successor (R2/R3/R4)", q, SUCC[s]);
    end

    // R7 serial pattern from zero: 0,1,0 repeating
    force_state(4'h0);
    for (int i = 0; i < 6; i++) begin
      chk("R7 y stream", {3'b0, y}, {3'b0, (i % 3) == 1});
      step();
    end

    // R5 hold with either enable low
    force_state(4'h5);
    @(negedge clk); cnt_en = 0;
    step(); step();
    chk("R5 hold cnt_en low", q, 4'h5);
    force_state(4'h8);
    @(negedge clk); cnt_en = 1; carry_en = 0;
    step();
    chk("R5 hold carry_en low", q, 4'h8);

    // R2, R3 act with enables low
    @(negedge clk); cnt_en = 0; carry_en = 0;
    force_state(4'h2); step();
    chk("R2 clear enables low", q, 4'h0);
    force_state(4'h6); step();
    chk("R2 clear over load", q, 4'h0);
    force_state(4'hE); step();
    chk("R3 reload enables low", q, 4'hC);

    // R6 carry gated by carry_en
    force_state(4'hF);
    chk("R6 carry off", {3'b0, carry}, 4'h0);
    @(negedge clk); carry_en = 1; #1;
    chk("R6 carry on", {3'b0, carry}, 4'h1);

    // R1 async reset mid-run
    @(negedge clk); #2; rst_n = 0; #1;
    chk("R1 async reset", q, 4'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule